// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block puts a small microcontroller to sleep and wakes it up again. Software writes a mode code into an 8-bit power mode register. The controller then gates the CPU clock. It also drives one enable per oscillator (main, internal high-speed, sub, low-frequency RC) and one clock enable per peripheral group. Which enables stay high depends on the chosen sleep depth: light sleep, deep sleep, or deepest sleep.

While asleep, the controller qualifies a vector of wake requests. A request counts only if two things hold. Its interrupt enable must be set, and the current sleep depth must permit that source. A source whose clock the depth removes cannot wake the device. On a qualified wake from light sleep the CPU clock returns on the next cycle. On a wake from either deep state, every oscillator is switched back on at once, and the CPU clock waits for a fixed settling count first. An active-low reset exits any state and restores the reset values.

The controller is assumed to run from an always-on clock (the sub clock). Each settling cycle is one cycle of `clk`.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, `cpu_clk_en` is 1, `osc_en` is 4'hF, `per_clk_en` is 8'hFF and `pcon_rdata` reads 8'h00.
- R2: Writing 8'h01 in run mode enters light sleep. `cpu_clk_en` drops to 0 in the cycle after the write, while `osc_en` stays 4'hF and `per_clk_en` stays 8'hFF.
- R3: In light sleep, any request whose `wake_en` bit is set wakes the device, including bit 8 (other internal interrupts). A request whose enable bit is clear leaves the device asleep.
- R4: Writing 8'h02 enters deep sleep. `osc_en` becomes 4'b1100 (bit 2 sub, bit 3 low-frequency RC; bit 0 main and bit 1 high-speed off). In `per_clk_en`, bit 0 (watchdog) and bit 1 (interval timer) are on, and bit 2 (watch timer) equals `watch_on_sub`. All other peripheral bits are 0.
- R5: Writing 8'h03 enters deepest sleep. `osc_en` becomes 4'b0100, and `per_clk_en` has only bit 2 possibly set, equal to `watch_on_sub`.
- R6: In deep sleep, these enabled wake bits wake the device: 0 event counter, 1 serial external clock, 2 external interrupt, 3 UART activity, 4 I2C slave, 6 watchdog and 7 interval timer. Bit 5 (watch timer) wakes only when `watch_on_sub` is 1. Bit 8 is ignored.
- R7: In deepest sleep, wake bits 6, 7 and 8 are ignored. Bits 0 to 4 wake the device, and bit 5 wakes it when `watch_on_sub` is 1.
- R8: In run mode, a write of any value other than 8'h01, 8'h02 or 8'h03 (including 8'h00) has no effect. The CPU clock stays on and the register reads 8'h00.
- R9: `pcon_rdata` shows the written mode code while asleep, and reads 8'h00 from the cycle after a qualified wake onward.
- R10: After a qualified wake from deep or deepest sleep, `osc_en` is 4'hF in the next cycle. `cpu_clk_en` stays 0 for SETTLE_CYCLES cycles and returns to 1 in the following cycle.
- R11: After a qualified wake from light sleep, `cpu_clk_en` is 1 in the next cycle.
- R12: If a write of a sleep code arrives in the same cycle as a request that would qualify in the requested mode, the write is dropped. The CPU clock is never gated, and the register reads 8'h00.
- R13: Asserting `rst_n` while asleep restores the R1 outputs at once. Internal state leaves reset two clock edges after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcon_wr | input | 1 | Power mode register write strobe |
| pcon_wdata | input | REG_W | Power mode register write data |
| pcon_rdata | output | REG_W | Power mode register read data |
| watch_on_sub | input | 1 | Watch timer is clocked from the sub oscillator |
| wake_req | input | 9 | Wake request per source |
| wake_en | input | 9 | Interrupt enable per source |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 4 | Oscillator enables: main, high-speed, sub, low-frequency RC |
| per_clk_en | output | 8 | Peripheral clock enables: watchdog, interval timer, watch timer, timers, ADC, buzzer, serial, I2C |

## Verification
The bench builds the controller with SETTLE_CYCLES set to 5 and REG_W at its default of 8. With a short settling count, the bench can observe the last gated cycle and the first restored cycle of every deep wake, alongside many other scenarios, while a behavioural model is compared on every clock. With the full 8-bit register, every malformed code can be tried, including values whose low bits look like a valid mode. The bench drives `watch_on_sub` both ways, so both the gated and the running watch-timer cases are reached in both deep states.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int NUM_OSC  = 4;
  localparam int NUM_PER  = 8;
  localparam int NUM_WAKE = 9;

  // oscillator enable positions
  localparam int OSC_MAIN = 0;
  localparam int OSC_HSI  = 1;
  localparam int OSC_SUB  = 2;
  localparam int OSC_LFRC = 3;

  // peripheral clock enable positions
  localparam int PER_WDOG  = 0;
  localparam int PER_INTV  = 1;
  localparam int PER_WATCH = 2;
  localparam int PER_TMR   = 3;
  localparam int PER_ADC   = 4;
  localparam int PER_BUZ   = 5;
  localparam int PER_SER   = 6;
  localparam int PER_I2C   = 7;

  // wake source positions; STOP-capable sources are packed low
  localparam int WK_EVCNT  = 0;
  localparam int WK_SERCLK = 1;
  localparam int WK_EXTINT = 2;
  localparam int WK_UART   = 3;
  localparam int WK_I2CS   = 4;
  localparam int WK_WATCH  = 5;
  localparam int WK_WDOG   = 6;
  localparam int WK_INTV   = 7;
  localparam int WK_OTHER  = 8;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_STOP1 = 2'd2,
    PM_STOP2 = 2'd3
  } pm_e;

  typedef enum logic [1:0] {
    SQ_RUN    = 2'd0,
    SQ_SLEEP  = 2'd1,
    SQ_SETTLE = 2'd2
  } sq_e;

endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual
  import pwr_seq_pkg::*;
(
  input  pm_e                 mode,
  input  logic                watch_on_sub,
  input  logic [NUM_WAKE-1:0] req,
  input  logic [NUM_WAKE-1:0] en,
  output logic [NUM_WAKE-1:0] allow,
  output logic                hit
);

  always_comb begin
    allow = '0;
    for (int i = 0; i < NUM_WAKE; i++) begin
      unique case (mode)
        PM_IDLE:  allow[i] = 1'b1;
        PM_STOP1: allow[i] = (i <= WK_INTV) && ((i != WK_WATCH) || watch_on_sub);
        PM_STOP2: allow[i] = (i <= WK_I2CS) || ((i == WK_WATCH) && watch_on_sub);
        default:  allow[i] = 1'b0;
      endcase
    end
  end

  assign hit = |(req & en & allow);

endmodule

// File: rtl/pwr_gate_map.sv
module pwr_gate_map
  import pwr_seq_pkg::*;
(
  input  sq_e                state,
  input  pm_e                mode,
  input  logic               watch_on_sub,
  output logic               cpu_en,
  output logic [NUM_OSC-1:0] osc_en,
  output logic [NUM_PER-1:0] per_en
);

  always_comb begin
    cpu_en = (state == SQ_RUN);
    osc_en = '1;
    per_en = '1;
    if (state != SQ_RUN) begin
      unique case (mode)
        PM_STOP1: begin
          osc_en            = '0;
          osc_en[OSC_SUB]   = 1'b1;
          osc_en[OSC_LFRC]  = 1'b1;
          per_en            = '0;
          per_en[PER_WDOG]  = 1'b1;
          per_en[PER_INTV]  = 1'b1;
          per_en[PER_WATCH] = watch_on_sub;
        end
        PM_STOP2: begin
          osc_en            = '0;
          osc_en[OSC_SUB]   = 1'b1;
          per_en            = '0;
          per_en[PER_WATCH] = watch_on_sub;
        end
        default: begin
          osc_en = '1;
          per_en = '1;
        end
      endcase
    end
    // settling: all oscillators back, peripherals stay at their sleep mask
    if (state == SQ_SETTLE) begin
      osc_en = '1;
    end
  end

endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int SETTLE_CYCLES = 1024
) (
  input  logic clk,
  input  logic arst_n,
  input  logic active,
  output logic done
);

  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done   = active && (cnt_q == CNT_LAST);
  assign cnt_en = active || (cnt_q != '0);

  always_comb begin
    if (!active || done) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_SETTLE_CNT_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q <= CNT_LAST);  // R10

  AST_SETTLE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
    !active |=> (cnt_q == '0));  // R10

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1024,
  parameter int REG_W         = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pcon_wr,
  input  logic [REG_W-1:0]    pcon_wdata,
  output logic [REG_W-1:0]    pcon_rdata,
  input  logic                watch_on_sub,
  input  logic [NUM_WAKE-1:0] wake_req,
  input  logic [NUM_WAKE-1:0] wake_en,
  output logic                cpu_clk_en,
  output logic [NUM_OSC-1:0]  osc_en,
  output logic [NUM_PER-1:0]  per_clk_en
);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign arst_n = rst_pipe_q[1];

  sq_e              state_q, state_d;
  pm_e              mode_q, mode_d;
  logic [REG_W-1:0] pcon_q, pcon_d;
  logic             seq_en;

  logic                wr_valid;
  pm_e                 req_mode;
  logic [NUM_WAKE-1:0] req_allow, cur_allow;
  logic                req_hit, cur_hit;
  logic                settle_done;

  assign wr_valid = pcon_wr && (pcon_wdata[REG_W-1:2] == '0) && (pcon_wdata[1:0] != 2'b00);
  assign req_mode = pm_e'(pcon_wdata[1:0]);

  pwr_wake_qual u_qual_req (
    .mode         (req_mode),
    .watch_on_sub (watch_on_sub),
    .req          (wake_req),
    .en           (wake_en),
    .allow        (req_allow),
    .hit          (req_hit)
  );

  pwr_wake_qual u_qual_cur (
    .mode         (mode_q),
    .watch_on_sub (watch_on_sub),
    .req          (wake_req),
    .en           (wake_en),
    .allow        (cur_allow),
    .hit          (cur_hit)
  );

  pwr_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk    (clk),
    .arst_n (arst_n),
    .active (state_q == SQ_SETTLE),
    .done   (settle_done)
  );

  pwr_gate_map u_gate (
    .state        (state_q),
    .mode         (mode_q),
    .watch_on_sub (watch_on_sub),
    .cpu_en       (cpu_clk_en),
    .osc_en       (osc_en),
    .per_en       (per_clk_en)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    pcon_d  = pcon_q;
    unique case (state_q)
      SQ_RUN: begin
        if (wr_valid && !req_hit) begin
          state_d = SQ_SLEEP;
          mode_d  = req_mode;
          pcon_d  = pcon_wdata;
        end
      end
      SQ_SLEEP: begin
        if (cur_hit) begin
          pcon_d = '0;
          if (mode_q == PM_IDLE) begin
            state_d = SQ_RUN;
            mode_d  = PM_RUN;
          end else begin
            state_d = SQ_SETTLE;
          end
        end
      end
      SQ_SETTLE: begin
        if (settle_done) begin
          state_d = SQ_RUN;
          mode_d  = PM_RUN;
        end
      end
      default: begin
        state_d = SQ_RUN;
        mode_d  = PM_RUN;
        pcon_d  = '0;
      end
    endcase
  end

  assign seq_en = (state_q != SQ_RUN) || pcon_wr;

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= SQ_RUN;
      mode_q  <= PM_RUN;
      pcon_q  <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      mode_q  <= mode_d;
      pcon_q  <= pcon_d;
    end
  end

  assign pcon_rdata = pcon_q;

  AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == SQ_RUN && pcon_wr && !wr_valid) |=> (cpu_clk_en && pcon_rdata == '0));  // R8

  AST_ENTRY_ABORT: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == SQ_RUN && wr_valid && |(wake_req & wake_en & req_allow)) |=> cpu_clk_en);  // R12

  AST_PCON_CLEAR_ON_WAKE: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == SQ_SLEEP && cur_hit) |=> (pcon_rdata == '0));  // R9

  AST_IDLE_WAKE_FAST: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == SQ_SLEEP && mode_q == PM_IDLE && cur_hit) |=> cpu_clk_en);  // R11

  AST_STOP2_NO_WDOG_WAKE: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_q == PM_STOP2) |-> (!cur_allow[WK_WDOG] && !cur_allow[WK_INTV] && !cur_allow[WK_OTHER]));  // R7

  AST_SETTLE_OSC_UP: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == SQ_SETTLE) |-> (&osc_en && !cpu_clk_en));  // R10

  AST_STOP2_LF_OFF: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == SQ_SLEEP && mode_q == PM_STOP2) |-> (!osc_en[OSC_LFRC] && !osc_en[OSC_MAIN] && !per_clk_en[PER_WDOG]));  // R5

  AST_ENTRY_GATES_CPU: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == SQ_RUN && wr_valid && !req_hit) |=> !cpu_clk_en);  // R2

endmodule

// File: tb/pwr_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb_top;

  localparam int SETTLE = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pcon_wr = 1'b0;
  logic [7:0] pcon_wdata = 8'h00;
  logic [7:0] pcon_rdata;
  logic       watch_on_sub = 1'b0;
  logic [8:0] wake_req = '0;
  logic [8:0] wake_en = '0;
  logic       cpu_clk_en;
  logic [3:0] osc_en;
  logic [7:0] per_clk_en;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl #(.SETTLE_CYCLES(SETTLE), .REG_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .pcon_wr(pcon_wr), .pcon_wdata(pcon_wdata),
    .pcon_rdata(pcon_rdata), .watch_on_sub(watch_on_sub), .wake_req(wake_req),
    .wake_en(wake_en), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .per_clk_en(per_clk_en)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  // behavioural model: phase 0 run, 1 asleep, 2 settling
  int m_phase = 0;
  int m_mode  = 0;
  int m_pcon  = 0;
  int m_cnt   = 0;
  int m_rcnt  = 0;

  function automatic bit allowed(int md, int i, bit ws);
    if (md == 1) return 1'b1;
    if (md == 2) return (i <= 7) && (i != 5 || ws);
    if (md == 3) return (i <= 4) || (i == 5 && ws);
    return 1'b0;
  endfunction

  function automatic bit any_hit(int md);
    for (int i = 0; i < 9; i++)
      if (wake_req[i] && wake_en[i] && allowed(md, i, watch_on_sub)) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_mode = 0; m_pcon = 0; m_cnt = 0; m_rcnt = 0;
    end else if (m_rcnt < 2) begin
      m_rcnt++;
      m_phase = 0; m_mode = 0; m_pcon = 0; m_cnt = 0;
    end else begin
      case (m_phase)
        0: if (pcon_wr && pcon_wdata >= 1 && pcon_wdata <= 3 && !any_hit(int'(pcon_wdata))) begin
             m_phase = 1; m_mode = int'(pcon_wdata); m_pcon = int'(pcon_wdata);
           end
        1: if (any_hit(m_mode)) begin
             m_pcon = 0;
             if (m_mode == 1) begin m_phase = 0; m_mode = 0; end
             else begin m_phase = 2; m_cnt = 0; end
           end
        default: if (m_cnt == SETTLE - 1) begin m_phase = 0; m_mode = 0; end
                 else m_cnt++;
      endcase
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    logic       e_cpu;
    logic [3:0] e_osc;
    logic [7:0] e_per;
    e_cpu = (m_phase == 0);
    e_osc = 4'hF;
    e_per = 8'hFF;
    if (m_phase != 0 && m_mode == 2) begin
      e_osc = 4'b1100; e_per = {5'b0, watch_on_sub, 2'b11};
    end else if (m_phase != 0 && m_mode == 3) begin
      e_osc = 4'b0100; e_per = {5'b0, watch_on_sub, 2'b00};
    end
    if (m_phase == 2) e_osc = 4'hF;
    chk(cpu_clk_en === e_cpu, {cur_req, " cpu_clk_en"}, 32'(cpu_clk_en), 32'(e_cpu));
    chk(osc_en === e_osc, {cur_req, " osc_en"}, 32'(osc_en), 32'(e_osc));
    chk(per_clk_en === e_per, {cur_req, " per_clk_en"}, 32'(per_clk_en), 32'(e_per));
    chk(pcon_rdata === 8'(m_pcon), {cur_req, " pcon_rdata"}, 32'(pcon_rdata), 32'(m_pcon));
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic write_pcon(logic [7:0] v);
    pcon_wr = 1'b1; pcon_wdata = v;
    cyc(1);
    pcon_wr = 1'b0; pcon_wdata = 8'h00;
  endtask

  task automatic pulse(int bitn);
    wake_req = '0; wake_req[bitn] = 1'b1;
    cyc(1);
    wake_req = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cur_req = "R1";
    cyc(4);
    chk(cpu_clk_en && osc_en == 4'hF && per_clk_en == 8'hFF && pcon_rdata == 8'h00,
        "R1 reset outputs", {cpu_clk_en, osc_en, per_clk_en, pcon_rdata}, {1'b1, 4'hF, 8'hFF, 8'h00});

    // light sleep
    cur_req = "R2";
    wake_en = 9'h0FF;
    write_pcon(8'h01);
    cyc(1);
    chk(!cpu_clk_en && osc_en == 4'hF && per_clk_en == 8'hFF, "R2 idle gating",
        {cpu_clk_en, osc_en, per_clk_en}, {1'b0, 4'hF, 8'hFF});
    cur_req = "R3";
    pulse(8);
    cyc(2);
    chk(!cpu_clk_en, "R3 disabled source ignored", 32'(cpu_clk_en), 0);
    chk(pcon_rdata == 8'h01, "R9 reads mode code", 32'(pcon_rdata), 1);
    cur_req = "R11";
    wake_en = 9'h1FF;
    pulse(8);
    chk(cpu_clk_en, "R11 idle wake next cycle", 32'(cpu_clk_en), 1);
    chk(pcon_rdata == 8'h00, "R9 cleared after wake", 32'(pcon_rdata), 0);
    cyc(2);

    // deep sleep, watch timer not on sub clock
    cur_req = "R4";
    watch_on_sub = 1'b0;
    write_pcon(8'h02);
    cyc(1);
    chk(osc_en == 4'hC && per_clk_en == 8'h03, "R4 stop1 gating",
        {osc_en, per_clk_en}, {4'hC, 8'h03});
    cur_req = "R6";
    pulse(5);
    pulse(8);
    cyc(1);
    chk(!cpu_clk_en && osc_en == 4'hC, "R6 watch/other ignored", {cpu_clk_en, osc_en}, {1'b0, 4'hC});
    cur_req = "R10";
    pulse(6);
    chk(osc_en == 4'hF && !cpu_clk_en, "R10 osc up first", {cpu_clk_en, osc_en}, {1'b0, 4'hF});
    cyc(SETTLE - 1);
    chk(!cpu_clk_en, "R10 still settling", 32'(cpu_clk_en), 0);
    cyc(1);
    chk(cpu_clk_en, "R10 cpu restored", 32'(cpu_clk_en), 1);
    cyc(2);

    // deep sleep, watch timer on sub clock
    cur_req = "R4";
    watch_on_sub = 1'b1;
    write_pcon(8'h02);
    cyc(1);
    chk(per_clk_en == 8'h07, "R4 watch clock kept", 32'(per_clk_en), 32'h07);
    cur_req = "R6";
    pulse(5);
    chk(osc_en == 4'hF && !cpu_clk_en, "R6 watch wakes stop1", {cpu_clk_en, osc_en}, {1'b0, 4'hF});
    cyc(SETTLE + 2);

    // deepest sleep
    cur_req = "R5";
    write_pcon(8'h03);
    cyc(1);
    chk(osc_en == 4'h4 && per_clk_en == 8'h04, "R5 stop2 gating", {osc_en, per_clk_en}, {4'h4, 8'h04});
    cur_req = "R7";
    pulse(6);
    pulse(7);
    pulse(8);
    cyc(1);
    chk(!cpu_clk_en && osc_en == 4'h4, "R7 wdog/intv/other ignored", {cpu_clk_en, osc_en}, {1'b0, 4'h4});
    watch_on_sub = 1'b0;
    cyc(1);
    chk(per_clk_en == 8'h00, "R5 watch clock off", 32'(per_clk_en), 0);
    pulse(5);
    chk(!cpu_clk_en && osc_en == 4'h4, "R7 gated watch ignored", {cpu_clk_en, osc_en}, {1'b0, 4'h4});
    pulse(2);
    chk(osc_en == 4'hF, "R7 ext interrupt wakes", 32'(osc_en), 32'hF);
    cyc(SETTLE + 2);

    // malformed writes
    cur_req = "R8";
    write_pcon(8'h04);
    write_pcon(8'hFF);
    write_pcon(8'h00);
    write_pcon(8'h81);
    cyc(1);
    chk(cpu_clk_en && pcon_rdata == 8'h00, "R8 bad codes ignored", {cpu_clk_en, pcon_rdata}, {1'b1, 8'h00});

    // abort on coincident wake
    cur_req = "R12";
    wake_req = 9'h001;
    write_pcon(8'h02);
    chk(cpu_clk_en && pcon_rdata == 8'h00, "R12 entry aborted", {cpu_clk_en, pcon_rdata}, {1'b1, 8'h00});
    cyc(1);
    wake_req = 9'h040;
    write_pcon(8'h03);
    wake_req = '0;
    chk(!cpu_clk_en && pcon_rdata == 8'h03, "R12 unqualified source no abort",
        {cpu_clk_en, pcon_rdata}, {1'b0, 8'h03});
    pulse(3);
    cyc(SETTLE + 2);

    // reset while asleep
    cur_req = "R13";
    write_pcon(8'h03);
    cyc(2);
    rst_n = 1'b0;
    cyc(1);
    chk(cpu_clk_en && osc_en == 4'hF && per_clk_en == 8'hFF && pcon_rdata == 8'h00,
        "R13 reset exits sleep", {cpu_clk_en, osc_en, per_clk_en, pcon_rdata}, {1'b1, 4'hF, 8'hFF, 8'h00});
    rst_n = 1'b1;
    write_pcon(8'h01);
    cyc(1);
    chk(cpu_clk_en, "R13 write ignored during reset release", 32'(cpu_clk_en), 1);
    cyc(2);
    write_pcon(8'h01);
    chk(!cpu_clk_en, "R13 active after release", 32'(cpu_clk_en), 0);
    pulse(0);
    cyc(2);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule